// File: doc/BRIEF.md
# Dual-DAC ADC Host Bus Interface

This block sits between an 8-bit parallel processor bus and a converter core. The core has one two-input ADC and two 8-bit DAC codes. The processor drives an active-low chip select, read and write strobes, and two address lines. One address line chooses between the ADC and the DAC side. The other chooses channel A or channel B.

Writing to the ADC side starts a conversion on the chosen input when the write strobe rises. The conversion engine is outside this block and is reached through a start pulse and a done pulse. Reading the ADC side returns the last result. Writing to the DAC side loads the chosen DAC register when the write strobe rises. If the read strobe is also held low during that write, the last ADC result is copied into the DAC register instead of the bus data.

An active-low interrupt is released by a write to the ADC or by a read, and it is pulled low when a conversion finishes. All bus strobes are sampled on the block clock, and their edges are found by comparing each sample with the previous one. The data bus is split into an input, an output and an output enable. Codes are offset binary, with bit 7 as the MSB.

Top module: `hbi_host_if`

## Requirements
- R1: While `cs_n` is high, no DAC register changes, no conversion starts and `irq_n_o` does not rise, whatever the other strobes do.
- R2: With `cs_n` low and `sel_dac` = 0 (ADC side), a rising `wr_n` gives a one-cycle `conv_start_o` pulse on the next cycle. `conv_ch_o` then holds the `ch_b` value sampled with that edge (0 = channel A, 1 = channel B).
- R3: With `cs_n` low, a falling `wr_n` with `sel_dac` = 0, or a falling `rd_n` with `sel_dac` = 0, drives `irq_n_o` high on the next cycle.
- R4: A cycle with `conv_done_i` high stores `conv_data_i` as the ADC result and drives `irq_n_o` low on the next cycle.
- R5: `data_oe_o` is high exactly while both `cs_n` and `rd_n` are low, and `data_o` then carries the ADC result. At any other time the bus is not driven.
- R6: With `cs_n` low, `sel_dac` = 1 and `rd_n` high, a rising `wr_n` loads `data_i` into DAC A (`ch_b` = 0) or DAC B (`ch_b` = 1). The other register keeps its value.
- R7: With `cs_n` low, `sel_dac` = 1 and `rd_n` low, a rising `wr_n` loads the last ADC result into the selected DAC register and ignores `data_i`.
- R8: After reset both DAC registers hold 0x80 (the midpoint), the ADC result is 0x00, `irq_n_o` is high and the bus is not driven.
- R9: If `cs_n` and `rd_n` stay low across a conversion, `data_o` shows the previous result until the conversion finishes and the new result after that.
- R10: Raising `cs_n` during a conversion releases the bus at once. The conversion still completes, storing its result and pulling `irq_n_o` low, and the result can be read once `cs_n` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; actions on its rising edge |
| sel_dac | input | 1 | Address: 0 = ADC side, 1 = DAC side |
| ch_b | input | 1 | Address: 0 = channel A, 1 = channel B |
| data_i | input | 8 | Bus data from the processor |
| data_o | output | 8 | Bus data to the processor (ADC result) |
| data_oe_o | output | 1 | Bus output enable; bus is high impedance when low |
| irq_n_o | output | 1 | Conversion-complete interrupt, active low |
| conv_start_o | output | 1 | One-cycle conversion start to the engine |
| conv_ch_o | output | 1 | Input channel for the conversion |
| conv_done_i | input | 1 | One-cycle completion pulse from the engine |
| conv_data_i | input | 8 | Result from the engine, valid with conv_done_i |
| dac_a_o | output | 8 | DAC A code |
| dac_b_o | output | 8 | DAC B code |

## Verification
Some rules can be checked on every cycle, and the assertions cover them:
- the bus stays released whenever chip select or read is high;
- a start pulse lasts one cycle and needs chip select;
- the interrupt goes low after every done pulse and rises only when chip select was low;
- the DAC codes stay frozen while the block is deselected.

Other behaviours depend on data values and on the order of operations, so only the bench scenarios show them. These are:
- which DAC register takes which value;
- that the copy path takes the result and not the bus;
- the switch from old to new result during a held read;
- a conversion that finishes while deselected.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
   // Width of the channel address (one line selects channel A or B)
   localparam int unsigned HBI_CH_W   = 1;
   localparam int unsigned HBI_NUM_CH = 2;
   typedef logic [HBI_CH_W-1:0] hbi_ch_t;
endpackage

// File: rtl/hbi_bus_decode.sv
// Samples the bus strobes, finds their edges and turns them into one-cycle
// events qualified by chip select and the address lines.
module hbi_bus_decode
   import hbi_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    cs_n,
   input  logic    rd_n,
   input  logic    wr_n,
   input  logic    sel_dac,
   input  hbi_ch_t ch_sel,
   output logic    adc_wr_fall_o,
   output logic    adc_rd_fall_o,
   output logic    adc_start_o,
   output logic    dac_load_o,
   output logic    dac_copy_o,
   output hbi_ch_t ch_o
);
   logic wr_q, rd_q;
   logic wr_fall, wr_rise, rd_fall, selected;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q <= 1'b1;
         rd_q <= 1'b1;
      end else begin
         wr_q <= wr_n;
         rd_q <= rd_n;
      end
   end

   always_comb begin
      wr_fall  = wr_q & ~wr_n;
      wr_rise  = ~wr_q & wr_n;
      rd_fall  = rd_q & ~rd_n;
      selected = ~cs_n;
      adc_wr_fall_o = selected & ~sel_dac & wr_fall;
      adc_rd_fall_o = selected & ~sel_dac & rd_fall;
      adc_start_o   = selected & ~sel_dac & wr_rise;
      dac_load_o    = selected &  sel_dac & wr_rise &  rd_n;
      dac_copy_o    = selected &  sel_dac & wr_rise & ~rd_n;
      ch_o          = ch_sel;
   end
endmodule

// File: rtl/hbi_conv_ctrl.sv
// Start handshake, result register and interrupt flag.
module hbi_conv_ctrl
   import hbi_pkg::*;
#(
   parameter int unsigned         DATA_W     = 8,
   parameter logic [DATA_W-1:0]   RESULT_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adc_wr_fall_i,
   input  logic              adc_rd_fall_i,
   input  logic              adc_start_i,
   input  hbi_ch_t           ch_i,
   input  logic              conv_done_i,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic              conv_start_o,
   output hbi_ch_t           conv_ch_o,
   output logic [DATA_W-1:0] result_o,
   output logic              irq_n_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_start_o <= 1'b0;
         conv_ch_o    <= '0;
         result_o     <= RESULT_RST;
         irq_n_o      <= 1'b1;
      end else begin
         conv_start_o <= adc_start_i;
         if (adc_start_i) conv_ch_o <= ch_i;
         if (conv_done_i) result_o <= conv_data_i;
         // completion wins over a release in the same cycle
         if (conv_done_i)                        irq_n_o <= 1'b0;
         else if (adc_wr_fall_i || adc_rd_fall_i) irq_n_o <= 1'b1;
      end
   end
endmodule

// File: rtl/hbi_dac_bank.sv
// One code register per DAC channel, loaded from the bus or from the result.
module hbi_dac_bank
   import hbi_pkg::*;
#(
   parameter int unsigned       DATA_W = 8,
   parameter int unsigned       NUM_CH = 2,
   parameter logic [DATA_W-1:0] RST_CODE = '0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          load_i,
   input  logic                          copy_i,
   input  hbi_ch_t                       ch_i,
   input  logic [DATA_W-1:0]             bus_data_i,
   input  logic [DATA_W-1:0]             result_i,
   output logic [NUM_CH-1:0][DATA_W-1:0] dac_o
);
   logic [DATA_W-1:0] next_code;
   assign next_code = copy_i ? result_i : bus_data_i;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = (load_i | copy_i) && (ch_i == hbi_ch_t'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   dac_o[i] <= RST_CODE;
         else if (hit) dac_o[i] <= next_code;
      end
   end
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if
   import hbi_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              sel_dac,
   input  logic              ch_b,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic              data_oe_o,
   output logic              irq_n_o,
   output logic              conv_start_o,
   output logic              conv_ch_o,
   input  logic              conv_done_i,
   input  logic [DATA_W-1:0] conv_data_i,
   output logic [DATA_W-1:0] dac_a_o,
   output logic [DATA_W-1:0] dac_b_o
);
   localparam int unsigned       NUM_CH   = HBI_NUM_CH;
   localparam logic [DATA_W-1:0] MID_CODE = DATA_W'(1) << (DATA_W - 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("hbi_host_if: DATA_W must be at least 2");
   end
   if (NUM_CH != 2) begin : g_bad_ch
      $error("hbi_host_if: one address line selects exactly two channels");
   end

   logic adc_wr_fall, adc_rd_fall, adc_start, dac_load, dac_copy;
   hbi_ch_t ch_evt, conv_ch;
   logic [DATA_W-1:0] result;
   logic [NUM_CH-1:0][DATA_W-1:0] dac_codes;

   hbi_bus_decode u_dec (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .sel_dac(sel_dac), .ch_sel(hbi_ch_t'(ch_b)),
      .adc_wr_fall_o(adc_wr_fall), .adc_rd_fall_o(adc_rd_fall),
      .adc_start_o(adc_start), .dac_load_o(dac_load), .dac_copy_o(dac_copy),
      .ch_o(ch_evt)
   );

   hbi_conv_ctrl #(.DATA_W(DATA_W), .RESULT_RST('0)) u_conv (
      .clk(clk), .rst_n(rst_n),
      .adc_wr_fall_i(adc_wr_fall), .adc_rd_fall_i(adc_rd_fall),
      .adc_start_i(adc_start), .ch_i(ch_evt),
      .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
      .conv_start_o(conv_start_o), .conv_ch_o(conv_ch),
      .result_o(result), .irq_n_o(irq_n_o)
   );

   hbi_dac_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .RST_CODE(MID_CODE)) u_dac (
      .clk(clk), .rst_n(rst_n), .load_i(dac_load), .copy_i(dac_copy),
      .ch_i(ch_evt), .bus_data_i(data_i), .result_i(result), .dac_o(dac_codes)
   );

   assign conv_ch_o = conv_ch[0];
   assign data_o    = result;
   assign data_oe_o = ~cs_n & ~rd_n;
   assign dac_a_o   = dac_codes[0];
   assign dac_b_o   = dac_codes[1];
endmodule

// File: rtl/hbi_host_if_checker.sv
module hbi_host_if_checker #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              rd_n,
   input logic              conv_start_o,
   input logic              conv_done_i,
   input logic              irq_n_o,
   input logic              data_oe_o,
   input logic [DATA_W-1:0] dac_a_o,
   input logic [DATA_W-1:0] dac_b_o
);
   AST_DAC_FROZEN_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> ($stable(dac_a_o) && $stable(dac_b_o))); // R1
   AST_START_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> $past(!cs_n)); // R2
   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |=> !conv_start_o); // R2
   AST_IRQ_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n_o) |-> $past(!cs_n)); // R3
   AST_IRQ_LOW_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done_i |=> !irq_n_o); // R4
   AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> !data_oe_o); // R5
endmodule

bind hbi_host_if hbi_host_if_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n),
   .conv_start_o(conv_start_o), .conv_done_i(conv_done_i),
   .irq_n_o(irq_n_o), .data_oe_o(data_oe_o),
   .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
);

// File: tb/hbi_host_if_bench.sv
module hbi_host_if_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, sel_dac = 1'b0, ch_b = 1'b0;
   logic [7:0] data_i = '0, conv_data_i = '0;
   logic conv_done_i = 1'b0;
   logic [7:0] data_o, dac_a_o, dac_b_o;
   logic data_oe_o, irq_n_o, conv_start_o, conv_ch_o;

   int checks = 0, errors = 0;
   logic exp_ch_q[$];
   logic [7:0] val_a = '0, val_b = '0;

   always #4 clk = ~clk;

   hbi_host_if u_hbi_host_if (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .sel_dac(sel_dac), .ch_b(ch_b), .data_i(data_i), .data_o(data_o),
      .data_oe_o(data_oe_o), .irq_n_o(irq_n_o), .conv_start_o(conv_start_o),
      .conv_ch_o(conv_ch_o), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
      .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      chk("R2 queue drained", 32'(exp_ch_q.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // Monitor: every start pulse must match a queued expectation
   always @(negedge clk) begin
      if (rst_n && conv_start_o) begin
         if (exp_ch_q.size() == 0) chk("R1 unexpected start", 1, 0);
         else chk("R2 start channel", 32'(conv_ch_o), 32'(exp_ch_q.pop_front()));
      end
   end

   // Conversion engine model: fixed latency, result chosen by channel
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && conv_start_o) begin
            automatic logic ch = conv_ch_o;
            repeat (4) @(negedge clk);
            conv_data_i = ch ? val_b : val_a;
            conv_done_i = 1'b1;
            @(negedge clk);
            conv_done_i = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   task automatic dac_write(input logic ch, input logic [7:0] val, input logic copy);
      @(negedge clk);
      cs_n = 0; sel_dac = 1; ch_b = ch; data_i = val; rd_n = copy ? 1'b0 : 1'b1; wr_n = 0;
      @(negedge clk);
      wr_n = 1;
      @(negedge clk);
      cs_n = 1; rd_n = 1; sel_dac = 0;
      @(negedge clk);
   endtask

   // Driver: pushes the expected channel, then pulses write with the ADC selected
   task automatic adc_start(input logic ch);
      @(negedge clk);
      cs_n = 0; sel_dac = 0; ch_b = ch; wr_n = 0;
      exp_ch_q.push_back(ch);
      @(negedge clk);
      wr_n = 1;
      @(negedge clk);
      cs_n = 1;
   endtask

   task automatic adc_read(input logic [7:0] exp, input string req);
      @(negedge clk);
      cs_n = 0; sel_dac = 0; rd_n = 0;
      @(negedge clk);
      chk({req, " oe"}, 32'(data_oe_o), 1);
      chk({req, " data"}, 32'(data_o), 32'(exp));
      chk("R3 read releases irq", 32'(irq_n_o), 1);
      rd_n = 1; cs_n = 1;
      @(negedge clk);
      chk("R5 bus released", 32'(data_oe_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R8 reset state
      chk("R8 dac a", 32'(dac_a_o), 32'h80);
      chk("R8 dac b", 32'(dac_b_o), 32'h80);
      chk("R8 irq", 32'(irq_n_o), 1);
      chk("R8 oe", 32'(data_oe_o), 0);

      // R6 bus loads
      dac_write(0, 8'h3C, 0);
      chk("R6 dac a", 32'(dac_a_o), 32'h3C);
      chk("R6 dac b kept", 32'(dac_b_o), 32'h80);
      dac_write(1, 8'hC5, 0);
      chk("R6 dac b", 32'(dac_b_o), 32'hC5);
      chk("R6 dac a kept", 32'(dac_a_o), 32'h3C);

      // R2/R4 conversion on channel A, R5 read
      val_a = 8'hA7; val_b = 8'h5E;
      adc_start(0);
      repeat (10) @(negedge clk);
      chk("R4 irq low after done", 32'(irq_n_o), 0);
      adc_read(8'hA7, "R5 read A");

      // channel B
      adc_start(1);
      repeat (10) @(negedge clk);
      adc_read(8'h5E, "R2 read B");

      // R7 copy ignores bus data
      dac_write(0, 8'hFF, 1);
      chk("R7 copy into a", 32'(dac_a_o), 32'h5E);
      chk("R7 b kept", 32'(dac_b_o), 32'hC5);

      // R3 write falling edge releases irq
      val_a = 8'h11;
      adc_start(0);
      repeat (10) @(negedge clk);
      chk("R4 irq low", 32'(irq_n_o), 0);
      @(negedge clk); cs_n = 0; sel_dac = 0; wr_n = 0;
      @(negedge clk);
      chk("R3 write fall releases irq", 32'(irq_n_o), 1);
      cs_n = 1;
      @(negedge clk); wr_n = 1;
      repeat (3) @(negedge clk);

      // R9 held read across a conversion
      val_a = 8'h22;
      @(negedge clk); cs_n = 0; sel_dac = 0; ch_b = 0; rd_n = 0;
      @(negedge clk); wr_n = 0; exp_ch_q.push_back(1'b0);
      @(negedge clk); wr_n = 1;
      @(negedge clk);
      chk("R9 previous result", 32'(data_o), 32'h11);
      chk("R9 bus driven", 32'(data_oe_o), 1);
      repeat (10) @(negedge clk);
      chk("R9 new result", 32'(data_o), 32'h22);
      rd_n = 1; cs_n = 1;
      @(negedge clk);

      // R10 deselect during conversion
      val_b = 8'h99;
      adc_start(1);
      rd_n = 0;
      @(negedge clk);
      chk("R10 bus released while deselected", 32'(data_oe_o), 0);
      repeat (10) @(negedge clk);
      chk("R10 irq low while deselected", 32'(irq_n_o), 0);
      rd_n = 1;
      // R1 strobes while deselected change nothing
      @(negedge clk); sel_dac = 1; ch_b = 0; data_i = 8'hAA; wr_n = 0;
      @(negedge clk); wr_n = 1;
      @(negedge clk); sel_dac = 0; wr_n = 0; rd_n = 0;
      @(negedge clk); wr_n = 1; rd_n = 1;
      repeat (3) @(negedge clk);
      chk("R1 dac a unchanged", 32'(dac_a_o), 32'h5E);
      chk("R1 irq unchanged", 32'(irq_n_o), 0);
      adc_read(8'h99, "R10 read after reselect");

      finish_run();
   end
endmodule